// File: doc/BRIEF.md
# Packed Decimal to Binary Loader

This block converts an 80-bit packed-decimal operand into a 64-bit binary magnitude and a separate sign flag. A later stage turns the pair into an extended-precision float. The operand holds eighteen decimal digits, four bits each, and one sign bit. The block handles one digit per clock. It starts at the most significant digit, and on each step it multiplies the running total by ten and adds the next digit. A conversion takes eighteen cycles.

The issuing pipeline raises `startReq` for one cycle and presents the operand. At the same time it reports on `slotBusy` whether the destination register slot is already occupied. If the slot is occupied, the block flags an overflow and does not convert. Every accepted start also emits a one-cycle strobe that tells the status logic to clear its rounding-direction condition bit. The integer-to-float step and all memory traffic live outside this block.

Top module: `pdec_loader`

## Requirements
- R1: After reset, `magOut` is 0, `negOut` is 0, and `busyOut`, `doneStb`, `ovfStb` and `c1ClrStb` are all low.
- R2: Digit k (k = 0..15) sits in operand bits 4k+3:4k, with digit 0 the least significant. Digit 16 sits in bits 67:64 and digit 17, the most significant, in bits 71:68. Bits 78:72 have no effect on the result.
- R3: When a conversion ends, `magOut` equals the sum over k of digit k times 10^k, formed in 64 bits.
- R4: `negOut` takes operand bit 79. The sign never changes `magOut`, so a set sign with all digits zero gives `magOut` = 0 and `negOut` = 1.
- R5: A start is accepted when `startReq` is high on a clock edge while `busyOut` is low. When `slotBusy` is low at that edge, `busyOut` is high for the next 18 cycles. `doneStb` pulses for exactly one cycle, 18 clock edges after the accepting edge, and `busyOut` falls at that same edge.
- R6: When `slotBusy` is high at the accepting edge, `ovfStb` pulses for one cycle after that edge. In that case `doneStb` does not pulse, `busyOut` stays low, and `magOut` and `negOut` keep their previous values.
- R7: Every accepted start, whether or not it overflows, produces a one-cycle pulse on `c1ClrStb` in the cycle after the accepting edge.
- R8: A `startReq` while `busyOut` is high is ignored. The running conversion completes with its own operand, and no extra `doneStb` follows.
- R9: Nibble values 10 to 15 are not rejected. Each is weighted by its raw value, so an operand of all 0xF digits gives 1666666666666666665.
- R10: `magOut` and `negOut` change only at the edge that raises `doneStb`, and they hold between conversions.
- R11: The operand is sampled only at the accepting edge. Changes to `operandIn` during a conversion do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a conversion |
| operandIn | input | 80 | Packed-decimal operand, sampled when a start is accepted |
| slotBusy | input | 1 | Destination slot occupied; an accepted start then signals overflow instead of converting |
| magOut | output | 64 | Binary magnitude of the last completed conversion |
| negOut | output | 1 | Sign of the last completed conversion |
| busyOut | output | 1 | Conversion in progress |
| doneStb | output | 1 | One-cycle pulse when `magOut`/`negOut` are updated |
| ovfStb | output | 1 | One-cycle pulse for a start refused because the slot is occupied |
| c1ClrStb | output | 1 | One-cycle pulse after every accepted start |

## Verification
On every cycle, the assertions check the handshake and timing rules:
- the fixed 18-edge latency, counted by the checker;
- the single-cycle, mutually exclusive strobes;
- the overflow and condition-clear pulses that follow an accepted start;
- the holding of the result between completions.

Numeric correctness can only be shown by the bench's scenarios, which compare results with a reference sum of weighted nibbles. These scenarios cover the digit placement, the sign handling including negative zero, raw non-decimal nibbles, and the ignored upper bits. The bench scenarios also show that a second start and operand changes during a conversion leave the result untouched.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  parameter int DIGITS  = 18;
  parameter int NIB_W   = 4;
  parameter int ACC_W   = 64;
  parameter int OP_W    = 80;
  parameter int SIGN_POS = OP_W - 1;
  localparam int DIG_BITS = DIGITS * NIB_W;
  localparam int IDX_W    = $clog2(DIGITS);

  typedef struct packed {
    logic             load;    // capture operand, clear accumulator
    logic             step;    // acc = acc*10 + digit[idx]
    logic             commit;  // last step: publish result
    logic [IDX_W-1:0] idx;     // digit currently consumed
  } pdec_ctl_t;
endpackage

// File: rtl/pdec_ctrl.sv
module pdec_ctrl
  import pdec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      slotBusy,
  output pdec_ctl_t ctl,
  output logic      busyOut,
  output logic      doneStb,
  output logic      ovfStb,
  output logic      c1ClrStb
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t           state;
  logic [IDX_W-1:0] digIdx;
  logic             accept;

  assign accept     = (state == ST_IDLE) && startReq;
  assign busyOut    = (state == ST_RUN);
  assign ctl.load   = accept && !slotBusy;
  assign ctl.step   = (state == ST_RUN);
  assign ctl.commit = (state == ST_RUN) && (digIdx == '0);
  assign ctl.idx    = digIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      digIdx   <= '0;
      doneStb  <= 1'b0;
      ovfStb   <= 1'b0;
      c1ClrStb <= 1'b0;
    end else begin
      doneStb  <= 1'b0;
      ovfStb   <= 1'b0;
      c1ClrStb <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            c1ClrStb <= 1'b1;
            if (slotBusy) begin
              ovfStb <= 1'b1;
            end else begin
              state  <= ST_RUN;
              digIdx <= IDX_W'(DIGITS - 1);
            end
          end
        end
        ST_RUN: begin
          if (digIdx == '0) begin
            doneStb <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            digIdx <= digIdx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdec_dpath.sv
module pdec_dpath
  import pdec_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  pdec_ctl_t       ctl,
  input  logic [OP_W-1:0] operandIn,
  output logic [ACC_W-1:0] magOut,
  output logic            negOut
);
  logic [DIG_BITS-1:0] digReg;
  logic                signReg;
  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    accNext;
  logic [NIB_W-1:0]    digitArr [DIGITS];
  logic [NIB_W-1:0]    curDigit;

  for (genvar g = 0; g < DIGITS; g++) begin : g_unpack
    assign digitArr[g] = digReg[g*NIB_W +: NIB_W];
  end

  assign curDigit = digitArr[ctl.idx];
  // times ten as shift-and-add; raw nibble value added as is
  assign accNext  = (acc << 3) + (acc << 1) + ACC_W'(curDigit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      digReg  <= '0;
      signReg <= 1'b0;
      acc     <= '0;
      magOut  <= '0;
      negOut  <= 1'b0;
    end else begin
      if (ctl.load) begin
        digReg  <= operandIn[DIG_BITS-1:0];
        signReg <= operandIn[SIGN_POS];
        acc     <= '0;
      end else if (ctl.step) begin
        acc <= accNext;
      end
      if (ctl.commit) begin
        magOut <= accNext;
        negOut <= signReg;
      end
    end
  end
endmodule

// File: rtl/pdec_loader.sv
module pdec_loader
  import pdec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [OP_W-1:0]  operandIn,
  input  logic             slotBusy,
  output logic [ACC_W-1:0] magOut,
  output logic             negOut,
  output logic             busyOut,
  output logic             doneStb,
  output logic             ovfStb,
  output logic             c1ClrStb
);
  pdec_ctl_t ctl;

  pdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .slotBusy(slotBusy),
    .ctl(ctl), .busyOut(busyOut), .doneStb(doneStb), .ovfStb(ovfStb),
    .c1ClrStb(c1ClrStb)
  );

  pdec_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .operandIn(operandIn),
    .magOut(magOut), .negOut(negOut)
  );
endmodule

// File: rtl/pdec_loader_chk.sv
module pdec_loader_chk
  import pdec_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             slotBusy,
  input logic [ACC_W-1:0] magOut,
  input logic             negOut,
  input logic             busyOut,
  input logic             doneStb,
  input logic             ovfStb,
  input logic             c1ClrStb
);
  localparam int CNT_W = $clog2(DIGITS + 2) + 1;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                                  runCnt <= '0;
    else if (startReq && !busyOut && !slotBusy) runCnt <= '0;
    else if (busyOut)                           runCnt <= runCnt + 1'b1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (runCnt == CNT_W'(DIGITS))); // R5
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (!busyOut && $past(busyOut))); // R5
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busyOut && !slotBusy) |=> busyOut); // R5
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busyOut && slotBusy) |=> (ovfStb && !busyOut)); // R6
  AST_OVF_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfStb && doneStb)); // R6
  AST_C1_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busyOut) |=> c1ClrStb); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !doneStb |-> ($stable(magOut) && $stable(negOut))); // R10
endmodule

bind pdec_loader pdec_loader_chk u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .slotBusy(slotBusy),
  .magOut(magOut), .negOut(negOut), .busyOut(busyOut), .doneStb(doneStb),
  .ovfStb(ovfStb), .c1ClrStb(c1ClrStb)
);

// File: tb/tb_pdec_loader.sv
module tb_pdec_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [79:0] operandIn = '0;
  logic        slotBusy = 1'b0;
  logic [63:0] magOut;
  logic        negOut, busyOut, doneStb, ovfStb, c1ClrStb;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pdec_loader dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .operandIn(operandIn),
    .slotBusy(slotBusy), .magOut(magOut), .negOut(negOut), .busyOut(busyOut),
    .doneStb(doneStb), .ovfStb(ovfStb), .c1ClrStb(c1ClrStb)
  );

  function automatic logic [63:0] refMag(input logic [79:0] op);
    logic [63:0] s = 0;
    logic [63:0] w = 1;
    for (int k = 0; k < 18; k++) begin
      s = s + 64'(op[4*k +: 4]) * w;
      w = w * 10;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Runs one conversion; returns at the negedge after the done strobe.
  task automatic runConv(input logic [79:0] op, input string req);
    int doneAt = -1;
    @(negedge clk);
    operandIn = op; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(c1ClrStb == 1'b1, "R7", 64'(c1ClrStb), 64'd1);
    for (int k = 1; k <= 24 && doneAt < 0; k++) begin
      @(negedge clk);
      if (doneStb) doneAt = k;
    end
    check(doneAt == 18, "R5", 64'(doneAt), 64'd18);
    check(magOut == refMag(op), req, magOut, refMag(op));
    check(negOut == op[79], "R4", 64'(negOut), 64'(op[79]));
  endtask

  task automatic tReset();
    check(magOut == 0 && negOut == 0, "R1", magOut, 64'd0);
    check({busyOut, doneStb, ovfStb, c1ClrStb} == 4'b0, "R1",
          64'({busyOut, doneStb, ovfStb, c1ClrStb}), 64'd0);
  endtask

  task automatic tValues();
    runConv(80'h0000_0000_0000_0000_0123, "R3");
    check(magOut == 64'd123, "R3", magOut, 64'd123);
    runConv(80'h0099_9999_9999_9999_9999, "R3");
    check(magOut == 64'd999999999999999999, "R3", magOut, 64'd999999999999999999);
    runConv(80'h0012_0000_0000_0000_0000, "R2");
    check(magOut == 64'd120000000000000000, "R2", magOut, 64'd120000000000000000);
  endtask

  task automatic tSign();
    runConv(80'h8000_0000_0000_0000_0042, "R4");
    check(magOut == 64'd42 && negOut, "R4", magOut, 64'd42);
    runConv(80'h8000_0000_0000_0000_0000, "R4");
    check(magOut == 64'd0 && negOut, "R4", 64'(negOut), 64'd1);
  endtask

  task automatic tRawNibbles();
    runConv(80'h00FF_FFFF_FFFF_FFFF_FFFF, "R9");
    check(magOut == 64'd1666666666666666665, "R9", magOut, 64'd1666666666666666665);
  endtask

  task automatic tUpperIgnored();
    runConv(80'h7F00_0000_0000_0000_0007, "R2");
    check(magOut == 64'd7 && !negOut, "R2", magOut, 64'd7);
  endtask

  task automatic tOverflow();
    logic [63:0] prevMag = magOut;
    logic        prevNeg = negOut;
    bit sawDone = 1'b0;
    @(negedge clk);
    operandIn = 80'h0000_0000_0000_0000_0555; startReq = 1'b1; slotBusy = 1'b1;
    @(negedge clk);
    startReq = 1'b0; slotBusy = 1'b0;
    check(ovfStb == 1'b1, "R6", 64'(ovfStb), 64'd1);
    check(c1ClrStb == 1'b1, "R7", 64'(c1ClrStb), 64'd1);
    check(busyOut == 1'b0, "R6", 64'(busyOut), 64'd0);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (doneStb) sawDone = 1'b1;
    end
    check(!sawDone, "R6", 64'(sawDone), 64'd0);
    check(magOut == prevMag && negOut == prevNeg, "R6", magOut, prevMag);
  endtask

  task automatic tBusyStart();
    logic [79:0] opA = 80'h8000_0000_0000_0031_4159;
    int doneCnt = 0;
    @(negedge clk);
    operandIn = opA; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 5) begin
        startReq = 1'b1; operandIn = 80'h0000_0000_0000_0000_0888;
      end else if (k == 6) begin
        startReq = 1'b0; operandIn = 80'h0011_1111_1111_1111_1111;
      end
      if (doneStb) doneCnt++;
      if (k == 18) check(doneStb == 1'b1, "R8", 64'(doneStb), 64'd1);
    end
    check(doneCnt == 1, "R8", 64'(doneCnt), 64'd1);
    check(magOut == refMag(opA) && negOut, "R11", magOut, refMag(opA));
  endtask

  task automatic tHold();
    logic [63:0] m = magOut;
    @(negedge clk); operandIn = '1;
    for (int k = 0; k < 5; k++) @(negedge clk);
    check(magOut == m, "R10", magOut, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tValues();
    tSign();
    tRawNibbles();
    tUpperIgnored();
    tOverflow();
    tBusyStart();
    tHold();
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule